// File: doc/BRIEF.md
# Triple-Redundant Serial Configuration Register Chain

This block keeps the static settings of a set of sensor channels in two independent serial chains: a configuration chain with a fixed number of bits per channel, and a calibration chain that carries the codes for each channel's DAC. A controller opens a load window and clocks the bitstreams in one bit per enabled cycle. When the window drops, both chains freeze. They then hold their contents for the rest of operation, and only a reset can open the window again.

Each stored bit exists in three flops. Every parallel output, and every bit that is shifted on, takes the 2-of-3 majority of the three copies. In every cycle without a shift, the voted value is written back into all three copies. A single particle-induced flip is therefore repaired at the next clock edge and never reaches an output. A sticky flag records that the voters have seen disagreement at some point. The top bit of each chain comes out on a serial pin. The controller can read the loaded stream back by shifting a second pass while the window is still open.

Top module: `tmr_cfg_chain`

## Requirements
- R1: In a cycle where loadWin and shiftEn are both high and the window has not closed, each chain moves one place toward its higher bit index. Bit 0 takes that chain's serial input.
- R2: A cycle with loadWin low or shiftEn low leaves both chains unchanged.
- R3: The window opens on the first cycle with loadWin high after reset. It closes on the first later cycle with loadWin low. Once closed, loadWin and shiftEn have no effect until reset.
- R4: Channel k's configuration field is cfgOut[k*CFG_BITS +: CFG_BITS]. Channel k's calibration code is calOut[k*CAL_BITS +: CAL_BITS].
- R5: cfgSerOut and calSerOut show the highest bit of their chain. The first bit shifted into a chain therefore appears there after as many shifts as the chain has bits, so a second pass reads the first pass back in order.
- R6: Each output bit is the 2-of-3 majority of its three stored copies. An upset in one copy does not change any output.
- R7: In every cycle without a shift, the voted value is written back into all copies. After one cycle, a different copy of the same bit can be upset without changing the output.
- R8: upsetSeen is set at the clock edge after any two copies of any bit differ. It stays set until reset.
- R9: Reset clears all copies and upsetSeen, and it reopens the load window.
- R10: The two chains shift on the same strobe but take independent serial inputs, and they have independent lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadWin | input | 1 | Load window from the controller |
| shiftEn | input | 1 | Shift enable for both chains |
| cfgSerIn | input | 1 | Serial input of the configuration chain |
| calSerIn | input | 1 | Serial input of the calibration chain |
| cfgOut | output | NUM_CH*CFG_BITS | Voted configuration fields, one per channel |
| calOut | output | NUM_CH*CAL_BITS | Voted DAC calibration codes, one per channel |
| cfgSerOut | output | 1 | Readback: voted top bit of the configuration chain |
| calSerOut | output | 1 | Readback: voted top bit of the calibration chain |
| upsetSeen | output | 1 | Sticky copy-disagreement flag |

## Verification
The bench builds the block with NUM_CH=4, CFG_BITS=3 and CAL_BITS=2. The chains are therefore 12 and 8 bits long, and a full load, a full readback pass and the decoding of every channel field each take only a few dozen cycles. Because the two lengths differ, a mix-up between the chains or an off-by-one in the shift length shows up on the outputs. Upsets are injected by overriding one copy register for a single cycle. This reaches the vote, scrub and sticky-flag behaviour, including a second upset in another copy of the same bit.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  typedef struct packed {
    logic shift;
    logic scrub;
  } chainStrobe_t;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_OPEN = 2'd1,
    WIN_SHUT = 2'd2
  } winState_t;
endpackage

// File: rtl/tmr_cfg_ctrl.sv
module tmr_cfg_ctrl
  import tmr_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadWin,
  input  logic         shiftEn,
  output chainStrobe_t strb
);
  winState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      WIN_IDLE: if (loadWin)  stateNxt = WIN_OPEN;
      WIN_OPEN: if (!loadWin) stateNxt = WIN_SHUT;
      default:                stateNxt = WIN_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WIN_IDLE;
    else       state <= stateNxt;
  end

  assign strb.shift = loadWin && shiftEn && (state != WIN_SHUT);
  assign strb.scrub = !strb.shift;

  // R3
  shut_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == WIN_SHUT) |=> (state == WIN_SHUT) && !strb.shift);
endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
  import tmr_cfg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainStrobe_t     strb,
  input  logic             serIn,
  output logic [WIDTH-1:0] voted,
  output logic             serOut,
  output logic             disagree
);
  logic [WIDTH-1:0] rep0, rep1, rep2;
  logic [WIDTH-1:0] shiftVal;

  assign voted    = (rep0 & rep1) | (rep0 & rep2) | (rep1 & rep2);
  assign disagree = |((rep0 ^ rep1) | (rep1 ^ rep2));
  assign serOut   = voted[WIDTH-1];

  generate
    if (WIDTH > 1) begin : g_wide
      assign shiftVal = {voted[WIDTH-2:0], serIn};
    end else begin : g_single
      assign shiftVal = serIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rep0 <= '0;
      rep1 <= '0;
      rep2 <= '0;
    end else if (strb.shift) begin
      rep0 <= shiftVal;
      rep1 <= shiftVal;
      rep2 <= shiftVal;
    end else if (strb.scrub) begin
      rep0 <= voted;
      rep1 <= voted;
      rep2 <= voted;
    end
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (voted[0] == $past(serIn)) &&
                   ((WIDTH < 2) || ((voted >> 1) == ($past(voted) & ~(WIDTH'(1) << (WIDTH-1))))));

  // R6
  vote_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(voted));
endmodule

// File: rtl/tmr_cfg_datapath.sv
module tmr_cfg_datapath
  import tmr_cfg_pkg::*;
#(
  parameter int CFG_W = 80,
  parameter int CAL_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainStrobe_t     strb,
  input  logic             cfgSerIn,
  input  logic             calSerIn,
  output logic [CFG_W-1:0] cfgOut,
  output logic [CAL_W-1:0] calOut,
  output logic             cfgSerOut,
  output logic             calSerOut,
  output logic             upsetSeen
);
  logic cfgDis, calDis;

  tmr_cfg_bank #(.WIDTH(CFG_W)) cfgBank (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(cfgSerIn),
    .voted(cfgOut), .serOut(cfgSerOut), .disagree(cfgDis)
  );

  tmr_cfg_bank #(.WIDTH(CAL_W)) calBank (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(calSerIn),
    .voted(calOut), .serOut(calSerOut), .disagree(calDis)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upsetSeen <= 1'b0;
    else       upsetSeen <= upsetSeen | cfgDis | calDis;
  end

  // R8
  upset_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    upsetSeen |=> upsetSeen);

  // R8
  upset_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDis || calDis) |=> upsetSeen);
endmodule

// File: rtl/tmr_cfg_chain.sv
module tmr_cfg_chain
  import tmr_cfg_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int CFG_BITS = 5,
  parameter int CAL_BITS = 8,
  localparam int CFG_W   = NUM_CH * CFG_BITS,
  localparam int CAL_W   = NUM_CH * CAL_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadWin,
  input  logic             shiftEn,
  input  logic             cfgSerIn,
  input  logic             calSerIn,
  output logic [CFG_W-1:0] cfgOut,
  output logic [CAL_W-1:0] calOut,
  output logic             cfgSerOut,
  output logic             calSerOut,
  output logic             upsetSeen
);
  chainStrobe_t strb;

  tmr_cfg_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .loadWin(loadWin), .shiftEn(shiftEn), .strb(strb)
  );

  tmr_cfg_datapath #(.CFG_W(CFG_W), .CAL_W(CAL_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSerIn(cfgSerIn), .calSerIn(calSerIn),
    .cfgOut(cfgOut), .calOut(calOut),
    .cfgSerOut(cfgSerOut), .calSerOut(calSerOut),
    .upsetSeen(upsetSeen)
  );
endmodule

// File: tb/tmr_cfg_chain_tb_top.sv
module tmr_cfg_chain_tb_top;
  localparam int NUM_CH = 4, CFG_BITS = 3, CAL_BITS = 2;
  localparam int CFG_W = NUM_CH * CFG_BITS;
  localparam int CAL_W = NUM_CH * CAL_BITS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, loadWin = 1'b0, shiftEn = 1'b0, cfgSerIn = 1'b0, calSerIn = 1'b0;
  logic [CFG_W-1:0] cfgOut;
  logic [CAL_W-1:0] calOut;
  logic cfgSerOut, calSerOut, upsetSeen;
  logic [CFG_W-1:0] injCfg;
  logic [CAL_W-1:0] injCal;

  tmr_cfg_chain #(.NUM_CH(NUM_CH), .CFG_BITS(CFG_BITS), .CAL_BITS(CAL_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .loadWin(loadWin), .shiftEn(shiftEn),
    .cfgSerIn(cfgSerIn), .calSerIn(calSerIn), .cfgOut(cfgOut), .calOut(calOut),
    .cfgSerOut(cfgSerOut), .calSerOut(calSerOut), .upsetSeen(upsetSeen)
  );

  int nChecks = 0, nFail = 0;
  bit cfgQ[$];
  bit calQ[$];
  int winSt = 0;
  bit expUpset = 0, pendUpset = 0;
  string tag = "R9";
  bit passA[CFG_W];

  function automatic logic [CFG_W-1:0] cfgVec();
    logic [CFG_W-1:0] v;
    for (int i = 0; i < CFG_W; i++) v[i] = cfgQ[i];
    return v;
  endfunction

  function automatic logic [CAL_W-1:0] calVec();
    logic [CAL_W-1:0] v;
    for (int i = 0; i < CAL_W; i++) v[i] = calQ[i];
    return v;
  endfunction

  task automatic chk(string name, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, name, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("cfgOut", 128'(cfgOut), 128'(cfgVec()));
    chk("calOut", 128'(calOut), 128'(calVec()));
    chk("cfgSerOut R5", 128'(cfgSerOut), 128'(cfgQ[CFG_W-1]));
    chk("calSerOut R5", 128'(calSerOut), 128'(calQ[CAL_W-1]));
    chk("upsetSeen R8", 128'(upsetSeen), 128'(expUpset));
  endtask

  task automatic modelReset();
    cfgQ.delete();
    calQ.delete();
    for (int i = 0; i < CFG_W; i++) cfgQ.push_back(1'b0);
    for (int i = 0; i < CAL_W; i++) calQ.push_back(1'b0);
    winSt = 0;
    expUpset = 0;
    pendUpset = 0;
  endtask

  task automatic tick(bit win, bit sh, bit ci, bit ki);
    loadWin = win; shiftEn = sh; cfgSerIn = ci; calSerIn = ki;
    @(posedge clk);
    if (win && sh && winSt != 2) begin
      cfgQ.push_front(ci); void'(cfgQ.pop_back());
      calQ.push_front(ki); void'(calQ.pop_back());
    end
    if (winSt == 0 && win) winSt = 1;
    else if (winSt == 1 && !win) winSt = 2;
    if (pendUpset) expUpset = 1;
    pendUpset = 0;
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic upsetCopy(bit calSide, int copy, int bitIdx);
    if (!calSide) begin
      injCfg = cfgVec() ^ (CFG_W'(1) << bitIdx);
      case (copy)
        0: begin force dut_i.dpI.cfgBank.rep0 = injCfg; #1; release dut_i.dpI.cfgBank.rep0; end
        1: begin force dut_i.dpI.cfgBank.rep1 = injCfg; #1; release dut_i.dpI.cfgBank.rep1; end
        default: begin force dut_i.dpI.cfgBank.rep2 = injCfg; #1; release dut_i.dpI.cfgBank.rep2; end
      endcase
    end else begin
      injCal = calVec() ^ (CAL_W'(1) << bitIdx);
      case (copy)
        0: begin force dut_i.dpI.calBank.rep0 = injCal; #1; release dut_i.dpI.calBank.rep0; end
        1: begin force dut_i.dpI.calBank.rep1 = injCal; #1; release dut_i.dpI.calBank.rep1; end
        default: begin force dut_i.dpI.calBank.rep2 = injCal; #1; release dut_i.dpI.calBank.rep2; end
      endcase
    end
    pendUpset = 1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    modelReset();
    // R9: reset state
    @(posedge clk); #1;
    compareAll();
    @(negedge clk);
    rstN = 1'b1;

    // R2: shifting without the window is ignored
    tag = "R2";
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b1, 1'b1);

    // R1 R10: load pass A with occasional stalls (R2)
    tag = "R1";
    for (int i = 0; i < CFG_W; i++) begin
      passA[i] = bit'(((i * 7 + 3) % 5) < 2);
      tick(1'b1, 1'b1, passA[i], bit'((i * 3 + 1) % 4 == 0));
      if (i % 4 == 2) begin
        tag = "R2";
        tick(1'b1, 1'b0, 1'b1, 1'b1);
        tag = "R1";
      end
    end

    // R5: second pass reads pass A back in order
    tag = "R5";
    for (int i = 0; i < CFG_W; i++) begin
      chk("R5 readback", 128'(cfgSerOut), 128'(passA[i]));
      tick(1'b1, 1'b1, bit'(i % 3 == 0), bit'(i % 2));
    end

    // R3: close window, then further attempts are ignored
    tag = "R3";
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, bit'(~cfgQ[0]), bit'(~calQ[0]));
    tick(1'b0, 1'b1, 1'b1, 1'b0);

    // R4: per-channel field placement
    tag = "R4";
    for (int k = 0; k < NUM_CH; k++) begin
      logic [CFG_BITS-1:0] ef;
      logic [CAL_BITS-1:0] ec;
      for (int b = 0; b < CFG_BITS; b++) ef[b] = cfgQ[k * CFG_BITS + b];
      for (int b = 0; b < CAL_BITS; b++) ec[b] = calQ[k * CAL_BITS + b];
      chk("R4 cfg field", 128'(cfgOut[k * CFG_BITS +: CFG_BITS]), 128'(ef));
      chk("R4 cal field", 128'(calOut[k * CAL_BITS +: CAL_BITS]), 128'(ec));
    end

    // R6 R8: single-copy upset is outvoted and flagged
    tag = "R6";
    chk("R8 flag clear before upset", 128'(upsetSeen), 128'(0));
    upsetCopy(1'b0, 1, 3);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    // R7: another copy of the same bit after scrub
    tag = "R7";
    upsetCopy(1'b0, 2, 3);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    upsetCopy(1'b0, 0, 3);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    upsetCopy(1'b1, 0, CAL_W - 1);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    upsetCopy(1'b1, 1, CAL_W - 1);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tag = "R8";
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);

    // R9: reset clears and reopens the window
    tag = "R9";
    rstN = 1'b0;
    #1;
    modelReset();
    compareAll();
    @(negedge clk);
    rstN = 1'b1;
    tag = "R1";
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1, bit'(i % 2));
    tag = "R3";
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b1);

    finishRun();
  end
endmodule